// File: doc/BRIEF.md
# Serial Port Status Flag Register

This block keeps the seven event flags of an asynchronous serial port and presents them as one status byte on a simple register bus. The transmit and receive datapaths raise flags with single-cycle pulses. Software acknowledges flags only through bus access sequences; writing the status register does nothing.

Each read of the status register takes a snapshot of the flags that are set at that moment. The snapshot is split into a receive part and a transmit part. A later read of the data register clears the receive flags that were in the snapshot. A later write of the data register clears the transmit flags that were in the snapshot. A flag that rises after the status read is not in the snapshot, so it stays set until software reads the status again. Each part of the snapshot is used up by the access that consumes it.

Top module: `ser_stat_reg`

## Requirements
- R1: A bus read at the status address returns, in the same cycle, bit 7 transmit-empty, bit 6 transmit-complete, bit 5 receive-full, bit 4 idle, bit 3 overrun, bit 2 noise, bit 1 framing error, and bit 0 as zero. `bus_rdata` is zero when no status read is in progress.
- R2: After reset the status byte reads 0xC0: both transmit flags are one and the other flags are zero.
- R3: A one on `evt_set[k]` in a cycle sets the flag at status bit k+1 from the next cycle on. The mapping is evt_set[6] transmit-empty, [5] transmit-complete, [4] receive-full, [3] idle, [2] overrun, [1] noise, [0] framing.
- R4: A write to the status address changes no flag.
- R5: A status read followed by a data-register read clears the receive flags (bits 5 to 1). The clear can be seen from the cycle after the data read.
- R6: The data-register read clears only the receive flags that were set at the most recent status read. A receive flag that sets between the two accesses stays set.
- R7: A status read followed by a data-register write clears the transmit flags (bits 7 and 6) that were set at that status read.
- R8: A data-register access with no status read since reset, or since the access that consumed the snapshot, clears nothing. A data read never clears transmit flags, and a data write never clears receive flags. Consuming one part of the snapshot leaves the other part armed.
- R9: When an event pulse and a clearing access hit the same flag in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W (3) | Register address; status at STAT_ADDR (0), data at DATA_ADDR (1) |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| evt_set | input | 7 | Single-cycle flag set pulses from the datapaths, mapped as in R3 |
| bus_rdata | output | 8 | Status byte during a status read, else zero |

## Verification
A datapath event and a clearing data access can land on the same flag in the same clock cycle. The bench provokes this case directly. It pulses the idle event during the data-register read that would clear idle, and it pulses transmit-empty during the data-register write that would clear it. In both cases the following status read must still show the flag set. A second race is a receive flag that rises between the status read and the data read. That flag must survive the data read while the flag that was in the snapshot is cleared.

// File: rtl/ser_stat_pkg.sv
package ser_stat_pkg;
  localparam int NUM_FLAGS = 7;
  localparam int BYTE_W    = NUM_FLAGS + 1;

  typedef logic [NUM_FLAGS-1:0] flag_vec_t;

  // flag positions inside the flag vector (status bit = position + 1)
  localparam int F_FRAME   = 0;
  localparam int F_NOISE   = 1;
  localparam int F_OVER    = 2;
  localparam int F_IDLE    = 3;
  localparam int F_RXFULL  = 4;
  localparam int F_TXDONE  = 5;
  localparam int F_TXEMPTY = 6;

  localparam flag_vec_t TX_MASK     = flag_vec_t'((1 << F_TXEMPTY) | (1 << F_TXDONE));
  localparam flag_vec_t RX_MASK     = ~TX_MASK;
  localparam flag_vec_t RESET_FLAGS = TX_MASK;
endpackage

// File: rtl/ser_stat_decode.sv
module ser_stat_decode #(
  parameter int ADDR_W    = 3,
  parameter int STAT_ADDR = 0,
  parameter int DATA_ADDR = 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  output logic              stat_rd,
  output logic              stat_wr,
  output logic              dat_rd,
  output logic              dat_wr
);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);
  localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_ADDR);

  logic hit_stat, hit_data;

  always_comb begin
    hit_stat = (addr == STAT_A);
    hit_data = (addr == DATA_A);
    stat_rd  = rd & hit_stat;
    stat_wr  = wr & hit_stat;
    dat_rd   = rd & hit_data;
    dat_wr   = wr & hit_data;
  end
endmodule

// File: rtl/ser_stat_arm.sv
module ser_stat_arm
  import ser_stat_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      stat_rd,
  input  logic      dat_rd,
  input  logic      dat_wr,
  input  flag_vec_t flags,
  output flag_vec_t rx_arm,
  output flag_vec_t tx_arm,
  output flag_vec_t clr
);
  flag_vec_t rx_arm_q, rx_arm_d, tx_arm_q, tx_arm_d;
  logic      arm_en;

  always_comb begin
    rx_arm_d = rx_arm_q;
    tx_arm_d = tx_arm_q;
    if (stat_rd) begin
      rx_arm_d = flags & RX_MASK;
      tx_arm_d = flags & TX_MASK;
    end else begin
      if (dat_rd) rx_arm_d = '0;
      if (dat_wr) tx_arm_d = '0;
    end
    arm_en = stat_rd | dat_rd | dat_wr;
    clr    = (dat_rd ? rx_arm_q : '0) | (dat_wr ? tx_arm_q : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_arm_q <= '0;
      tx_arm_q <= '0;
    end else if (arm_en) begin
      rx_arm_q <= rx_arm_d;
      tx_arm_q <= tx_arm_d;
    end
  end

  assign rx_arm = rx_arm_q;
  assign tx_arm = tx_arm_q;

  assert_rx_consumed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_rd && !stat_rd) |=> (rx_arm_q == '0));
  assert_tx_consumed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && !stat_rd) |=> (tx_arm_q == '0));
  assert_snapshot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> ((rx_arm_q | tx_arm_q) == $past(flags)));
endmodule

// File: rtl/ser_stat_flag.sv
module ser_stat_flag #(
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  logic q_r, q_d, en;

  always_comb begin
    en  = set | clr;
    q_d = set | (q_r & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q_r <= RST_VAL;
    else if (en) q_r <= q_d;
  end

  assign q = q_r;

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> q_r);
  assert_clear_takes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !q_r);
endmodule

// File: rtl/ser_stat_reg.sv
module ser_stat_reg
  import ser_stat_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int STAT_ADDR = 0,
  parameter int DATA_ADDR = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_rd,
  input  logic                 bus_wr,
  input  logic [NUM_FLAGS-1:0] evt_set,
  output logic [BYTE_W-1:0]    bus_rdata
);
  logic      rst_ff1, rst_sync_n;
  logic      stat_rd, stat_wr, dat_rd, dat_wr;
  flag_vec_t flags_q, clr, rx_arm, tx_arm;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_ff1    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_ff1    <= 1'b1;
      rst_sync_n <= rst_ff1;
    end
  end

  ser_stat_decode #(
    .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .DATA_ADDR(DATA_ADDR)
  ) u_decode (
    .addr(bus_addr), .rd(bus_rd), .wr(bus_wr),
    .stat_rd(stat_rd), .stat_wr(stat_wr), .dat_rd(dat_rd), .dat_wr(dat_wr)
  );

  ser_stat_arm u_arm (
    .clk(clk), .rst_n(rst_sync_n),
    .stat_rd(stat_rd), .dat_rd(dat_rd), .dat_wr(dat_wr),
    .flags(flags_q), .rx_arm(rx_arm), .tx_arm(tx_arm), .clr(clr)
  );

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    ser_stat_flag #(.RST_VAL(RESET_FLAGS[i])) u_flag (
      .clk(clk), .rst_n(rst_sync_n),
      .set(evt_set[i]), .clr(clr[i]), .q(flags_q[i])
    );

    assert_keep_unarmed_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (flags_q[i] && !((dat_rd && rx_arm[i]) || (dat_wr && tx_arm[i]))) |=> flags_q[i]);
  end

  always_comb begin
    bus_rdata = '0;
    if (stat_rd) bus_rdata = {flags_q, 1'b0};
  end

  assert_status_write_inert_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (stat_wr && (evt_set == '0)) |=> $stable(flags_q));
  assert_bit0_zero_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !bus_rdata[0]);
endmodule

// File: tb/ser_stat_reg_tb.sv
module ser_stat_reg_tb;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd0;
  localparam logic [ADDR_W-1:0] A_DATA = 3'd1;
  // event bits
  localparam logic [6:0] E_NONE = 7'h00, E_FRAME = 7'h01, E_OVER = 7'h04,
                         E_IDLE = 7'h08, E_RXF = 7'h10, E_TXE = 7'h40;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [ADDR_W-1:0] bus_addr;
  logic              bus_rd, bus_wr;
  logic [6:0]        evt_set;
  logic [7:0]        bus_rdata;

  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk = ~clk;

  ser_stat_reg u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .evt_set(evt_set), .bus_rdata(bus_rdata)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; bus_rd = 0; bus_wr = 0; bus_addr = '0; evt_set = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // one bus cycle; returns read data sampled mid-cycle
  task automatic cyc(input logic rd, input logic wr, input logic [ADDR_W-1:0] a,
                     input logic [6:0] ev, output logic [7:0] rdat);
    @(negedge clk);
    bus_rd = rd; bus_wr = wr; bus_addr = a; evt_set = ev;
    #1 rdat = bus_rdata;
    @(posedge clk);
    #1 bus_rd = 0; bus_wr = 0; evt_set = '0;
  endtask

  task automatic stat_rd(output logic [7:0] v); cyc(1, 0, A_STAT, E_NONE, v); endtask
  task automatic pulse(input logic [6:0] ev); logic [7:0] d; cyc(0, 0, A_STAT, ev, d); endtask
  task automatic data_rd(input logic [6:0] ev); logic [7:0] d; cyc(1, 0, A_DATA, ev, d); endtask
  task automatic data_wr(input logic [6:0] ev); logic [7:0] d; cyc(0, 1, A_DATA, ev, d); endtask

  task automatic t_reset();
    logic [7:0] v;
    do_reset(); stat_rd(v); check("R2 reset value", v, 8'hC0);
    @(negedge clk); #1 check("R1 idle bus reads zero", bus_rdata, 8'h00);
  endtask

  task automatic t_no_prior_read();
    logic [7:0] v;
    do_reset(); data_wr(E_NONE); data_rd(E_NONE); stat_rd(v);
    check("R8 data access without status read", v, 8'hC0);
  endtask

  task automatic t_status_write();
    logic [7:0] v, d;
    do_reset(); pulse(E_IDLE); cyc(0, 1, A_STAT, E_NONE, d); stat_rd(v);
    check("R4 status write inert", v, 8'hD0);
  endtask

  task automatic t_layout();
    logic [7:0] v;
    do_reset(); pulse(E_FRAME); stat_rd(v); check("R1/R3 framing at bit1", v, 8'hC2);
    pulse(E_OVER); stat_rd(v); check("R1/R3 overrun at bit3", v, 8'hCA);
    pulse(7'h02); stat_rd(v); check("R3 noise at bit2", v, 8'hCE);
  endtask

  task automatic t_rx_clear();
    logic [7:0] v;
    do_reset(); pulse(E_RXF | E_IDLE); stat_rd(v); check("R3 rx flags set", v, 8'hF0);
    data_rd(E_NONE); stat_rd(v); check("R5 rx flags cleared, tx kept", v, 8'hC0);
  endtask

  task automatic t_partial();
    logic [7:0] v;
    do_reset(); pulse(E_RXF); stat_rd(v); check("R6 pre-read", v, 8'hE0);
    pulse(E_OVER); data_rd(E_NONE); stat_rd(v);
    check("R6 late flag survives", v, 8'hC8);
  endtask

  task automatic t_tx_clear();
    logic [7:0] v;
    do_reset(); stat_rd(v); data_wr(E_NONE); stat_rd(v);
    check("R7 tx flags cleared", v, 8'h00);
    pulse(E_TXE); stat_rd(v); check("R3 transmit-empty sets", v, 8'h80);
  endtask

  task automatic t_separation();
    logic [7:0] v;
    do_reset(); pulse(E_RXF); stat_rd(v);
    data_rd(E_NONE); data_wr(E_NONE); stat_rd(v);
    check("R8 tx arm survives data read", v, 8'h00);
    do_reset(); pulse(E_RXF); stat_rd(v); data_wr(E_NONE); stat_rd(v);
    check("R8 data write leaves rx", v, 8'h20);
  endtask

  task automatic t_consumed();
    logic [7:0] v;
    do_reset(); pulse(E_RXF); stat_rd(v); data_rd(E_NONE);
    pulse(E_RXF); data_rd(E_NONE); stat_rd(v);
    check("R8 snapshot consumed once", v, 8'hE0);
  endtask

  task automatic t_set_wins();
    logic [7:0] v;
    do_reset(); pulse(E_IDLE); stat_rd(v); data_rd(E_IDLE); stat_rd(v);
    check("R9 idle set beats clear", v, 8'hD0);
    data_wr(E_TXE); stat_rd(v);
    check("R9 transmit-empty set beats clear", v, 8'hD0 & 8'hBF | 8'h80);
  endtask

  initial begin
    #1_000_000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    t_reset();
    t_no_prior_read();
    t_status_write();
    t_layout();
    t_rx_clear();
    t_partial();
    t_tx_clear();
    t_separation();
    t_consumed();
    t_set_wins();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule